// File: doc/BRIEF.md
# Free-Running 64-Bit Counter With Match Interrupt

This block keeps a 64-bit up-counter that advances while running and a 64-bit match value. Both are reached through a 32-bit register port, one word at a time. A programmable prescaler sets how many clock cycles pass between counter steps. While matching is enabled, an event flag goes up once the count is at or beyond the match value. Software clears the flag by writing a one to it. The interrupt pin shows the flag only when the interrupt enable is set.

With the self-advance option on, the match value adds a programmed step each time it matches. This gives a steady train of events with no software reload. The counter is read in two halves, and the high half can change between the two reads. Software that needs a consistent 64-bit value reads high, then low, then high again, and retries if the two high values differ.

Writes take effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`. Only word-aligned offsets are decoded. Unmapped or misaligned offsets read zero and ignore writes.

Top module: `wallclk_top`

## Requirements
- R1: After reset every register (count, control, status, match value, step) reads zero and `irq_o` is low.
- R2: While control bit 0 (run) is 0 the count holds its value; writing control to zero stops a running counter.
- R3: With run set and a prescale of 0, the count grows by one every clock cycle, and the low word (offset 0x0) carries into the high word (offset 0x4).
- R4: The prescale field is control bits [15:8]; with value p, the count grows by one every p+1 cycles, the first step coming p+1 cycles after run is set.
- R5: Writing offset 0x0 or 0x4 replaces that half of the count; a write takes priority over a step in the same cycle.
- R6: With control bit 1 (match enable) set, the status flag (offset 0xC bit 0) is set one cycle after the full 64-bit count is at or above the match value (low word 0x10, high word 0x14), even while the counter is stopped.
- R7: Writing 1 to status bit 0 clears the flag; writing 0 leaves it; if a match holds in the same cycle the flag stays set.
- R8: `irq_o` is high exactly when the flag is set and control bit 2 (interrupt enable) is set.
- R9: With control bit 3 (self-advance) set, each cycle with a match adds the 32-bit step register (offset 0x18, zero-extended) to the match value; with bit 3 clear the match value changes only by writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt: flag gated by interrupt enable |

## Verification
A register write lands at the edge on which it is strobed. With prescale 0 the first step comes one edge after that. The flag and `irq_o` trail the matching count by one further edge, and a self-advanced match value appears at that same edge. The bench drives and reads on falling edges. Each task counts whole edges from the write that starts its scenario and predicts the count, flag and match value at that edge number. Matches and carries are checked on both sides of their due edge: one edge early for the old value, and at the due edge for the new one.

// File: rtl/wallclk_pkg.sv
package wallclk_pkg;

    localparam int WORD_W    = 32;
    localparam int CNT_W     = 64;
    localparam int HALVES    = CNT_W / WORD_W;
    localparam int ADDR_W    = 5;
    localparam int PRESC_W   = 8;
    localparam int PRESC_LSB = 8;

    typedef enum logic [2:0] {
        RS_CNT_LO = 3'd0,
        RS_CNT_HI = 3'd1,
        RS_CTRL   = 3'd2,
        RS_STAT   = 3'd3,
        RS_CMP_LO = 3'd4,
        RS_CMP_HI = 3'd5,
        RS_STEP   = 3'd6,
        RS_NONE   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic               auto_step;
        logic               irq_en;
        logic               cmp_en;
        logic               run;
    } ctrl_t;

    typedef struct packed {
        logic cnt_lo;
        logic cnt_hi;
        logic ctrl;
        logic stat;
        logic cmp_lo;
        logic cmp_hi;
        logic step;
    } wr_strobe_t;

    function automatic ctrl_t word_to_ctrl(logic [WORD_W-1:0] w);
        ctrl_t c;
        c.run       = w[0];
        c.cmp_en    = w[1];
        c.irq_en    = w[2];
        c.auto_step = w[3];
        c.presc     = w[PRESC_LSB +: PRESC_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_to_word(ctrl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[0] = c.run;
        w[1] = c.cmp_en;
        w[2] = c.irq_en;
        w[3] = c.auto_step;
        w[PRESC_LSB +: PRESC_W] = c.presc;
        return w;
    endfunction

    function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00)
            return RS_NONE;
        return reg_sel_e'(a[ADDR_W-1:2]);
    endfunction

endpackage

// File: rtl/wallclk_regif.sv
module wallclk_regif
    import wallclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  cmp,
    input  logic              flag,
    output ctrl_t             ctrl,
    output logic [WORD_W-1:0] step,
    output wr_strobe_t        strobe,
    output logic [WORD_W-1:0] rdata
);

    reg_sel_e sel;

    always_comb begin
        sel    = decode_addr(addr);
        strobe = '0;
        if (wr) begin
            unique case (sel)
                RS_CNT_LO: strobe.cnt_lo = 1'b1;
                RS_CNT_HI: strobe.cnt_hi = 1'b1;
                RS_CTRL:   strobe.ctrl   = 1'b1;
                RS_STAT:   strobe.stat   = 1'b1;
                RS_CMP_LO: strobe.cmp_lo = 1'b1;
                RS_CMP_HI: strobe.cmp_hi = 1'b1;
                RS_STEP:   strobe.step   = 1'b1;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            step <= '0;
        end else begin
            if (strobe.ctrl) ctrl <= word_to_ctrl(wdata);
            if (strobe.step) step <= wdata;
        end
    end

    always_comb begin
        unique case (sel)
            RS_CNT_LO: rdata = count[WORD_W-1:0];
            RS_CNT_HI: rdata = count[CNT_W-1:WORD_W];
            RS_CTRL:   rdata = ctrl_to_word(ctrl);
            RS_STAT:   rdata = {{(WORD_W-1){1'b0}}, flag};
            RS_CMP_LO: rdata = cmp[WORD_W-1:0];
            RS_CMP_HI: rdata = cmp[CNT_W-1:WORD_W];
            RS_STEP:   rdata = step;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/wallclk_prescale.sv
module wallclk_prescale
    import wallclk_pkg::*;
#(
    parameter int P_W = PRESC_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run,
    input  logic [P_W-1:0] presc,
    output logic           tick
);

    logic [P_W-1:0] div_cnt;

    assign tick = run && (div_cnt >= presc);

    always_ff @(posedge clk) begin
        if (rst || !run)
            div_cnt <= '0;
        else if (tick)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + 1'b1;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && presc != '0) |=> (!tick || presc == '0)); // R4

endmodule

// File: rtl/wallclk_counter.sv
module wallclk_counter
    import wallclk_pkg::*;
#(
    parameter int C_W = CNT_W,
    parameter int W_W = WORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [C_W/W_W-1:0]   wr_half,
    input  logic [W_W-1:0]       wdata,
    output logic [C_W-1:0]       count
);

    localparam int NH = C_W / W_W;

    logic [C_W-1:0] nxt;

    always_comb begin
        nxt = count + {{(C_W-1){1'b0}}, tick};
        for (int h = 0; h < NH; h++)
            if (wr_half[h]) nxt[h*W_W +: W_W] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= nxt;
    end

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!tick && wr_half == '0) |=> $stable(count)); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (tick && wr_half == '0) |=> count == $past(count) + 1'b1); // R3

endmodule

// File: rtl/wallclk_match.sv
module wallclk_match
    import wallclk_pkg::*;
#(
    parameter int C_W = CNT_W,
    parameter int W_W = WORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [C_W-1:0]       count,
    input  logic                 cmp_en,
    input  logic                 auto_step,
    input  logic [W_W-1:0]       step,
    input  logic [C_W/W_W-1:0]   wr_half,
    input  logic [W_W-1:0]       wdata,
    input  logic                 clr,
    output logic [C_W-1:0]       cmp,
    output logic                 flag
);

    localparam int NH = C_W / W_W;

    logic           hit;
    logic [C_W-1:0] step_ext;
    logic [C_W-1:0] cmp_nxt;

    assign hit      = cmp_en && (count >= cmp);
    assign step_ext = {{(C_W-W_W){1'b0}}, step};

    always_comb begin
        cmp_nxt = cmp;
        if (hit && auto_step)
            cmp_nxt = cmp + step_ext;
        for (int h = 0; h < NH; h++)
            if (wr_half[h]) cmp_nxt[h*W_W +: W_W] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp  <= '0;
            flag <= 1'b0;
        end else begin
            cmp <= cmp_nxt;
            if (hit)      flag <= 1'b1;
            else if (clr) flag <= 1'b0;
        end
    end

    AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !flag); // R7
    AST_AUTO_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (hit && auto_step && wr_half == '0) |=> cmp == $past(cmp) + $past(step_ext)); // R9
    AST_CMP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!(hit && auto_step) && wr_half == '0) |=> $stable(cmp)); // R9

endmodule

// File: rtl/wallclk_top.sv
module wallclk_top
    import wallclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_o
);

    ctrl_t             ctrl;
    wr_strobe_t        strobe;
    logic [WORD_W-1:0] step;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  cmp;
    logic              flag;
    logic              tick;
    logic [HALVES-1:0] cnt_wr;
    logic [HALVES-1:0] cmp_wr;

    assign cnt_wr = {strobe.cnt_hi, strobe.cnt_lo};
    assign cmp_wr = {strobe.cmp_hi, strobe.cmp_lo};

    wallclk_regif u_regif (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .wdata  (bus_wdata),
        .count  (count),
        .cmp    (cmp),
        .flag   (flag),
        .ctrl   (ctrl),
        .step   (step),
        .strobe (strobe),
        .rdata  (bus_rdata)
    );

    wallclk_prescale u_presc (
        .clk   (clk),
        .rst   (rst),
        .run   (ctrl.run),
        .presc (ctrl.presc),
        .tick  (tick)
    );

    wallclk_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_half (cnt_wr),
        .wdata   (bus_wdata),
        .count   (count)
    );

    wallclk_match u_match (
        .clk       (clk),
        .rst       (rst),
        .count     (count),
        .cmp_en    (ctrl.cmp_en),
        .auto_step (ctrl.auto_step),
        .step      (step),
        .wr_half   (cmp_wr),
        .wdata     (bus_wdata),
        .clr       (strobe.stat && bus_wdata[0]),
        .cmp       (cmp),
        .flag      (flag)
    );

    assign irq_o = flag && ctrl.irq_en;

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> flag); // R8

endmodule

// File: tb/sim_wallclk_top.sv
`timescale 1ns/100ps
module sim_wallclk_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [4:0] A_CLO = 5'h00, A_CHI = 5'h04, A_CTL = 5'h08,
                           A_STA = 5'h0C, A_MLO = 5'h10, A_MHI = 5'h14,
                           A_STP = 5'h18;

    always #2.5 clk = ~clk;

    wallclk_top u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(logic [4:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic edges(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic halt_and_load(logic [31:0] hi, logic [31:0] lo);
        wr(A_CTL, 32'h0);
        wr(A_CHI, hi);
        wr(A_CLO, lo);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CLO, v); check("R1 count lo", v, 0);
        rd(A_CHI, v); check("R1 count hi", v, 0);
        rd(A_CTL, v); check("R1 control", v, 0);
        rd(A_STA, v); check("R1 status", v, 0);
        rd(A_MLO, v); check("R1 match lo", v, 0);
        rd(A_MHI, v); check("R1 match hi", v, 0);
        rd(A_STP, v); check("R1 step", v, 0);
        check("R1 irq", irq_o, 0);
        edges(10);
        rd(A_CLO, v); check("R2 idle count", v, 0);
    endtask

    task automatic t_run_fast();
        logic [31:0] v;
        wr(A_CTL, 32'h1);
        edges(20);
        rd(A_CLO, v); check("R3 count after 20 cycles", v, 20);
        wr(A_CTL, 32'h0);
        rd(A_CLO, v); check("R2 stop value", v, 21);
        edges(10);
        rd(A_CLO, v); check("R2 held after stop", v, 21);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        halt_and_load(0, 0);
        wr(A_CTL, 32'h0000_0301);
        edges(19);
        rd(A_CLO, v); check("R4 presc 3 before 5th step", v, 4);
        edges(1);
        rd(A_CLO, v); check("R4 presc 3 at 5th step", v, 5);
    endtask

    task automatic t_carry_and_write();
        logic [31:0] v;
        halt_and_load(32'h1, 32'hFFFF_FFFE);
        wr(A_CTL, 32'h1);
        edges(1);
        rd(A_CHI, v); check("R3 hi before carry", v, 1);
        edges(2);
        rd(A_CLO, v); check("R3 lo after carry", v, 1);
        rd(A_CHI, v); check("R3 hi after carry", v, 2);
        wr(A_CLO, 32'h100);
        rd(A_CLO, v); check("R5 write wins over step", v, 32'h100);
        rd(A_CHI, v); check("R5 other half kept", v, 2);
    endtask

    task automatic t_match();
        logic [31:0] v;
        halt_and_load(0, 0);
        wr(A_MHI, 0);
        wr(A_MLO, 10);
        wr(A_CTL, 32'h7);
        edges(10);
        rd(A_STA, v); check("R6 no flag before match edge", v, 0);
        check("R8 irq low before match", irq_o, 0);
        edges(1);
        rd(A_STA, v); check("R6 flag after count reaches match", v, 1);
        check("R8 irq with enable", irq_o, 1);
        rd(A_MLO, v); check("R9 match kept without self-advance", v, 10);
        wr(A_CTL, 32'h3);
        check("R8 irq masked", irq_o, 0);
        rd(A_STA, v); check("R8 flag still set when masked", v, 1);
        wr(A_STA, 32'h0);
        rd(A_STA, v); check("R7 writing 0 keeps flag", v, 1);
        wr(A_CTL, 32'h1);
        wr(A_STA, 32'h1);
        rd(A_STA, v); check("R7 writing 1 clears flag", v, 0);
        edges(3);
        rd(A_STA, v); check("R7 flag stays clear", v, 0);
    endtask

    task automatic t_wide_compare();
        logic [31:0] v;
        halt_and_load(0, 32'hFFFF_FFFF);
        wr(A_MHI, 1);
        wr(A_MLO, 0);
        wr(A_CTL, 32'h2);
        edges(3);
        rd(A_STA, v); check("R6 high word decides compare", v, 0);
        wr(A_CHI, 1);
        edges(1);
        rd(A_STA, v); check("R6 flag while stopped above match", v, 1);
        wr(A_STA, 32'h1);
        rd(A_STA, v); check("R7 set wins over clear", v, 1);
        wr(A_CTL, 32'h0);
        wr(A_STA, 32'h1);
    endtask

    task automatic t_auto_step();
        logic [31:0] v;
        halt_and_load(0, 0);
        wr(A_MHI, 0);
        wr(A_MLO, 5);
        wr(A_STP, 8);
        wr(A_CTL, 32'hF);
        edges(5);
        rd(A_MLO, v); check("R9 match before first hit", v, 5);
        edges(1);
        rd(A_MLO, v); check("R9 first advance", v, 13);
        edges(19);
        rd(A_MLO, v); check("R9 after three hits", v, 29);
        rd(A_STA, v); check("R6 flag in self-advance mode", v, 1);
        check("R8 irq in self-advance mode", irq_o, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_run_fast();
        t_prescale();
        t_carry_and_write();
        t_match();
        t_wide_compare();
        t_auto_step();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule